// File: doc/BRIEF.md
# Utilization-Based Interrupt Moderator

This block decides when one traffic direction of a network port should interrupt the host. It counts completed frames and watches the most recent link-utilization sample. Four utilization bands each pair an upper bound in percent with a frame-count threshold. The current utilization selects one band, and that band's threshold decides how many completed frames must build up before a utilization interrupt fires. Light traffic therefore gets quick interrupts, and heavy traffic is coalesced into fewer ones.

A second, independent source is an interval timer. It counts microsecond ticks. Normally it fires at the end of an interval only if frames completed during that interval. In continuous mode it fires at every interval. With auto-cancel set, each utilization interrupt restarts the interval, so the timer only covers traffic that the utilization rule left waiting. A global enable silences both sources and clears their state.

Top module: `irq_moderator`

## Requirements
- R1: The utilization value is captured only in cycles where `util_valid_i` is high. It is held between samples and is 0 after reset.
- R2: Band 0 is checked first, then bands 1, 2 and 3. The first band whose bound is greater than or equal to the held utilization supplies the active frame threshold. Band k's bound is `band_bound_i[k*PCT_W +: PCT_W]` and its threshold is `band_thresh_i[k*CNT_W +: CNT_W]`.
- R3: A utilization interrupt fires when a band matches, the frame count is nonzero, and the count is greater than or equal to the active threshold. `util_irq_o` is high for exactly the cycle after the clock edge at which the condition held. A frame strobe sampled at edge k can therefore raise the pulse after edge k+1 at the earliest.
- R4: When no band's bound reaches the held utilization, no utilization interrupt fires, and frames keep being counted.
- R5: The frame count saturates at 2^CNT_W-1 (65535 by default) and does not wrap.
- R6: When a utilization interrupt fires, the count is cleared. A frame sampled in that same cycle leaves the count at 1.
- R7: The timer advances on each `us_tick_i`. An interval ends on the tick that brings the tick count to `timer_ival_i`. At the end of an interval, `timer_irq_o` pulses one cycle later if frames completed during the interval, including a frame in the ending cycle.
- R8: With continuous mode off, an interval that saw no frames ends without a timer pulse.
- R9: With continuous mode on, every interval end produces a timer pulse, whether or not there was traffic.
- R10: With auto-cancel on, a utilization interrupt restarts the timer interval and forgets its traffic. If an interval would end in that same cycle, it produces no timer pulse.
- R11: A `timer_ival_i` of 0 disables the timer source.
- R12: While `enable_i` is low, both outputs stay low, and the frame count and the timer are held cleared.
- R13: During and right after reset, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global enable for both sources |
| frame_done_i | input | 1 | One-cycle strobe per completed frame |
| util_valid_i | input | 1 | Qualifies a new utilization sample |
| util_pct_i | input | PCT_W (7) | Utilization sample, percent |
| us_tick_i | input | 1 | One-cycle microsecond tick |
| band_bound_i | input | NUM_BANDS*PCT_W (28) | Packed per-band upper bounds, band 0 in the low bits |
| band_thresh_i | input | NUM_BANDS*CNT_W (64) | Packed per-band frame thresholds, band 0 in the low bits |
| timer_ival_i | input | TMR_W (16) | Timer interval in ticks, 0 disables |
| auto_cancel_i | input | 1 | Restart the interval on each utilization interrupt |
| continuous_i | input | 1 | Fire the timer on every interval |
| util_irq_o | output | 1 | Utilization interrupt pulse |
| timer_irq_o | output | 1 | Timer interrupt pulse |

## Verification
The bench builds the block with CNT_W=8, so the counter saturates at 255. A few hundred back-to-back frames, held under a utilization that no band covers, then show the difference between saturation and wrap-around once a band with threshold 255 is selected. The interval stays at the default 16-bit width but is programmed to 4 ticks, with one tick every third clock. This gives intervals of twelve cycles, so continuous mode, idle intervals and auto-cancel races all occur many times within a short run.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int unsigned PCT_MAX = 100;

  function automatic logic [15:0] ones16(input int unsigned w);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) if (i < int'(w)) r[i] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/irqm_band_sel.sv
module irqm_band_sel #(
  parameter int unsigned NUM_BANDS = 4,
  parameter int unsigned PCT_W     = 7,
  parameter int unsigned CNT_W     = 16
) (
  input  logic [PCT_W-1:0]           util_i,
  input  logic [NUM_BANDS*PCT_W-1:0] bound_i,
  input  logic [NUM_BANDS*CNT_W-1:0] thresh_i,
  output logic                       match_o,
  output logic [CNT_W-1:0]           thresh_o
);
  logic [PCT_W-1:0] bnd [NUM_BANDS];
  logic [CNT_W-1:0] thr [NUM_BANDS];

  for (genvar g = 0; g < NUM_BANDS; g++) begin : g_unpack
    assign bnd[g] = bound_i[g*PCT_W +: PCT_W];
    assign thr[g] = thresh_i[g*CNT_W +: CNT_W];
  end

  // Scan from the last band down so the lowest-numbered match wins.
  always_comb begin
    match_o  = 1'b0;
    thresh_o = '0;
    for (int i = NUM_BANDS - 1; i >= 0; i--) begin
      if (util_i <= bnd[i]) begin
        match_o  = 1'b1;
        thresh_o = thr[i];
      end
    end
  end
endmodule

// File: rtl/irqm_frame_acc.sv
module irqm_frame_acc #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             frame_i,
  input  logic             match_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             fire_o,
  output logic             util_irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign fire_o = enable_i && match_i && (cnt_q != '0) && (cnt_q >= thresh_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      util_irq_o <= 1'b0;
    end else begin
      util_irq_o <= fire_o;
      if (!enable_i)                         cnt_q <= '0;
      else if (fire_o)                       cnt_q <= frame_i ? CNT_W'(1) : '0;
      else if (frame_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_clear_on_fire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    util_irq_o |-> (cnt_q <= CNT_W'(1)));

  assert_saturate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && frame_i && !fire_o && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  assert_needs_frames_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |=> !util_irq_o);
endmodule

// File: rtl/irqm_ival_timer.sv
module irqm_ival_timer #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic             frame_i,
  input  logic [TMR_W-1:0] ival_i,
  input  logic             auto_cancel_i,
  input  logic             continuous_i,
  input  logic             util_fire_i,
  output logic             timer_irq_o
);
  logic [TMR_W-1:0] tmr_q;
  logic             traffic_q;
  logic             active, cancel, done;

  assign active = enable_i && (ival_i != '0);
  assign cancel = active && auto_cancel_i && util_fire_i;
  // >= keeps a shrunk interval from waiting for a wrap
  assign done   = active && tick_i && (tmr_q >= ival_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q       <= '0;
      traffic_q   <= 1'b0;
      timer_irq_o <= 1'b0;
    end else begin
      timer_irq_o <= done && !cancel && (continuous_i || traffic_q || frame_i);
      if (!active || cancel || done) begin
        tmr_q     <= '0;
        traffic_q <= 1'b0;
      end else begin
        if (tick_i) tmr_q <= tmr_q + 1'b1;
        traffic_q <= traffic_q | frame_i;
      end
    end
  end

  assert_timer_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ival_i == '0) |=> !timer_irq_o);

  assert_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_irq_o |-> $past(tick_i));

  assert_cancel_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_cancel_i && util_fire_i) |=> !timer_irq_o);

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!continuous_i && !traffic_q && !frame_i) |=> !timer_irq_o);
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator #(
  parameter int unsigned NUM_BANDS = 4,
  parameter int unsigned PCT_W     = 7,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned TMR_W     = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       enable_i,
  input  logic                       frame_done_i,
  input  logic                       util_valid_i,
  input  logic [PCT_W-1:0]           util_pct_i,
  input  logic                       us_tick_i,
  input  logic [NUM_BANDS*PCT_W-1:0] band_bound_i,
  input  logic [NUM_BANDS*CNT_W-1:0] band_thresh_i,
  input  logic [TMR_W-1:0]           timer_ival_i,
  input  logic                       auto_cancel_i,
  input  logic                       continuous_i,
  output logic                       util_irq_o,
  output logic                       timer_irq_o
);
  logic [PCT_W-1:0] util_q;
  logic             match;
  logic [CNT_W-1:0] act_thresh;
  logic             util_fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           util_q <= '0;
    else if (util_valid_i) util_q <= util_pct_i;
  end

  irqm_band_sel #(.NUM_BANDS(NUM_BANDS), .PCT_W(PCT_W), .CNT_W(CNT_W)) u_band_sel (
    .util_i   (util_q),
    .bound_i  (band_bound_i),
    .thresh_i (band_thresh_i),
    .match_o  (match),
    .thresh_o (act_thresh)
  );

  irqm_frame_acc #(.CNT_W(CNT_W)) u_frame_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .frame_i    (frame_done_i),
    .match_i    (match),
    .thresh_i   (act_thresh),
    .fire_o     (util_fire),
    .util_irq_o (util_irq_o)
  );

  irqm_ival_timer #(.TMR_W(TMR_W)) u_ival_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .tick_i        (us_tick_i),
    .frame_i       (frame_done_i),
    .ival_i        (timer_ival_i),
    .auto_cancel_i (auto_cancel_i),
    .continuous_i  (continuous_i),
    .util_fire_i   (util_fire),
    .timer_irq_o   (timer_irq_o)
  );

  assert_disabled_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!util_irq_o && !timer_irq_o));

  assert_held_util_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !util_valid_i |=> $stable(util_q));
endmodule

// File: tb/irq_moderator_bench.sv
module irq_moderator_bench;
  localparam int NB = 4, PW = 7, CW = 8, TW = 16;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, frame = 1'b0, uvalid = 1'b0, tick = 1'b0, auto_c = 1'b0, cont = 1'b0;
  logic [PW-1:0] upct = '0;
  logic [TW-1:0] ival = '0;
  logic tick_en = 1'b0;
  int   bnd [NB];
  int   thr [NB];
  logic [NB*PW-1:0] bnd_flat;
  logic [NB*CW-1:0] thr_flat;
  logic util_irq, timer_irq;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      bnd_flat[i*PW +: PW] = PW'(bnd[i]);
      thr_flat[i*CW +: CW] = CW'(thr[i]);
    end
  end

  irq_moderator #(.NUM_BANDS(NB), .PCT_W(PW), .CNT_W(CW), .TMR_W(TW)) u_irq_moderator (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .frame_done_i(frame),
    .util_valid_i(uvalid), .util_pct_i(upct), .us_tick_i(tick),
    .band_bound_i(bnd_flat), .band_thresh_i(thr_flat), .timer_ival_i(ival),
    .auto_cancel_i(auto_c), .continuous_i(cont),
    .util_irq_o(util_irq), .timer_irq_o(timer_irq)
  );

  int checks = 0, fails = 0;
  string cur_req = "R13";

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference
  int m_util = 0, m_cnt = 0, m_tmr = 0;
  bit m_traffic = 0, e_u = 0, e_t = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_util = 0; m_cnt = 0; m_tmr = 0; m_traffic = 0; e_u = 0; e_t = 0;
    end else begin
      bit match, fire, cancel, fin;
      int th;
      match = 0; th = 0;
      for (int i = 0; i < NB; i++)
        if (!match && m_util <= bnd[i]) begin match = 1; th = thr[i]; end
      fire   = en && match && m_cnt > 0 && m_cnt >= th;
      cancel = en && ival != 0 && auto_c && fire;
      fin    = en && ival != 0 && tick && (m_tmr >= int'(ival) - 1);
      e_u = fire;
      e_t = fin && !cancel && (cont || m_traffic || frame);
      if (!en) m_cnt = 0;
      else if (fire) m_cnt = frame ? 1 : 0;
      else if (frame && m_cnt < CMAX) m_cnt++;
      if (!en || ival == 0 || cancel || fin) begin m_tmr = 0; m_traffic = 0; end
      else begin
        if (tick) m_tmr++;
        m_traffic = m_traffic | frame;
      end
      if (uvalid) m_util = upct;
    end
  end

  int obs_u = 0, obs_t = 0, mod_t = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check({cur_req, " util_irq per-cycle"}, util_irq, e_u);
      check({cur_req, " timer_irq per-cycle"}, timer_irq, e_t);
      if (util_irq) obs_u++;
      if (timer_irq) obs_t++;
      if (e_t) mod_t++;
    end
  end

  int tdiv = 0;
  always @(negedge clk) begin
    if (tick_en) begin
      tdiv = (tdiv == 2) ? 0 : tdiv + 1;
      tick <= (tdiv == 2);
    end else tick <= 1'b0;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic set_util(input int v);
    @(negedge clk); upct = PW'(v); uvalid = 1'b1;
    @(negedge clk); uvalid = 1'b0;
  endtask
  task automatic frames(input int n, input int gap);
    repeat (n) begin
      @(negedge clk); frame = 1'b1;
      @(negedge clk); frame = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  int su, st, smt;
  task automatic mark();
    su = obs_u; st = obs_t; smt = mod_t;
  endtask

  initial begin
    bnd[0] = 20; bnd[1] = 50; bnd[2] = 80; bnd[3] = 95;
    thr[0] = 2;  thr[1] = 4;  thr[2] = 6;  thr[3] = 8;
    idle(3);
    check("R13 util_irq in reset", util_irq, 0);
    check("R13 timer_irq in reset", timer_irq, 0);
    @(negedge clk); rst_n = 1'b1; en = 1'b1;
    idle(2);
    check("R13 util_irq after reset", util_irq, 0);
    check("R13 timer_irq after reset", timer_irq, 0);

    cur_req = "R3"; set_util(10); mark();
    frames(10, 2); idle(6);
    check("R3 band0 pulses", obs_u - su, 5);

    cur_req = "R2"; set_util(60); mark();
    frames(12, 2); idle(6);
    check("R2 band2 pulses", obs_u - su, 2);

    cur_req = "R4"; set_util(99); mark();
    @(negedge clk); upct = PW'(10);  // R1: no valid, must be ignored
    frames(20, 1); idle(6);
    check("R4 no band match", obs_u - su, 0);
    check("R1 sample ignored without valid", obs_u - su, 0);

    cur_req = "R5"; frames(300, 0);
    thr[2] = 255; idle(2); mark();
    set_util(60); idle(6);
    check("R5 saturated count reaches 255", obs_u - su, 1);
    cur_req = "R6";
    check("R6 pulses after clear", util_irq, 0);
    thr[2] = 6;

    cur_req = "R8"; set_util(99); ival = TW'(4); tick_en = 1'b1; mark();
    idle(60);
    check("R8 idle intervals silent", obs_t - st, 0);
    cur_req = "R7"; mark();
    frames(1, 0); idle(30);
    check("R7 one traffic interval", obs_t - st, 1);

    cur_req = "R9"; cont = 1'b1; mark();
    idle(120);
    check("R9 continuous matches model", obs_t - st, mod_t - smt);
    check("R9 continuous at least 9", int'((obs_t - st) >= 9), 1);

    cur_req = "R10"; auto_c = 1'b1; set_util(10);
    @(negedge clk); ival = '0; @(negedge clk); ival = TW'(4); mark();
    repeat (15) begin frames(2, 0); idle(4); end
    check("R10 auto-cancel suppresses timer", obs_t - st, 0);
    check("R6 util pulses during cancel run", obs_u - su, 15);
    auto_c = 1'b0;

    cur_req = "R11"; ival = '0; mark();
    idle(60);
    check("R11 zero interval silent", obs_t - st, 0);

    cur_req = "R12"; ival = TW'(4); @(negedge clk); en = 1'b0; mark();
    frames(20, 1); idle(30);
    check("R12 util quiet when disabled", obs_u - su, 0);
    check("R12 timer quiet when disabled", obs_t - st, 0);
    en = 1'b1; cont = 1'b0; mark();
    frames(1, 3); idle(8);
    check("R12 count cleared while disabled", obs_u - su, 0);
    idle(4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule